// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

This block is a 4-bit counter that takes one step per rising clock edge, up or down as a direction input selects. An active-low load input forces the data inputs into the count asynchronously and takes priority over counting. An active-low enable lets the count advance. When several counters are chained, each stage's enable also acts as the carry or borrow coming from the stage below.

Two outputs support chaining. A terminal flag is high when the count has reached the last value for the current direction. A gated ripple output goes low during the low half of the clock when the stage is enabled and at its terminal value. A parameter picks binary counting (modulo 16) or decade counting (modulo 10). To build a wider counter, the enable of the next stage is formed from the enable of the stage below and that stage's terminal flag.

Top module: `updown_cascade_counter`

## Requirements
- R1: While `rst_ni` is low, the count is 0.
- R2: The count changes only on a rising clock edge. While `enable_ni` is high (1 = hold), the count keeps its value across edges.
- R3: While `load_ni` is low, `count_o` equals `data_i`. It takes the new value without waiting for a clock edge, and it overrides `enable_ni`.
- R4: With `down_i` low (0 = up), each enabled edge adds 1. In binary mode the count wraps from 15 to 0.
- R5: With `down_i` high (1 = down), each enabled edge subtracts 1. In binary mode the count wraps from 0 to 15.
- R6: `max_min_o` is high exactly when the count is at its terminal value: 15 in binary mode or 9 in decade mode when counting up, and 0 when counting down. A change of `down_i` shows on `max_min_o` without a clock edge.
- R7: `ripple_no` is low only while `clk_i` is low, `enable_ni` is low and `max_min_o` is high. In every other case it is high.
- R8: In decade mode the count wraps from 9 to 0 when counting up and from 0 to 9 when counting down.
- R9: In decade mode, a loaded value from 10 to 15 becomes valid on the first enabled edge. Counting up it becomes 0, and counting down it becomes 9.
- R10: Two binary stages form an 8-bit counter in both directions when the upper stage's enable is the OR of the lower stage's `enable_ni` and the inverted `max_min_o` of the lower stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the count changes on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_ni | input | 1 | Asynchronous parallel load, active low |
| data_i | input | WIDTH | Value to load |
| enable_ni | input | 1 | Count enable and cascade carry/borrow input, active low |
| down_i | input | 1 | Direction: 0 counts up, 1 counts down |
| count_o | output | WIDTH | Current count |
| max_min_o | output | 1 | Terminal value reached for the current direction |
| ripple_no | output | 1 | Gated carry/borrow for the next stage, active low |

## Verification
The main function is exercised with long enabled runs up and down through a two-stage binary chain while a decade instance runs alongside. These runs separate a correct nibble carry or borrow (0x0F to 0x10 and back) from a stuck or early one. Held-enable stretches and loads made with enable active separate hold and override from counting. Loads at 0x00, 0xFF and the decade edge values, plus loads of 10, 12, 14 and 15 into the decade stage, tell the wrap paths apart from out-of-range recovery. Flipping direction at the terminal value, and checking the ripple output in both clock phases, separate the combinational flags from anything registered.

// File: rtl/updown_counter_pkg.sv
package updown_counter_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;

  function automatic int unsigned term_count(bit decade, int unsigned width);
    return decade ? 9 : (1 << width) - 1;
  endfunction
endpackage

// File: rtl/updown_next.sv
module updown_next
  import updown_counter_pkg::*;
#(
  parameter int unsigned WIDTH  = 4,
  parameter bit          DECADE = 1'b0
) (
  input  logic [WIDTH-1:0] cur_i,
  input  dir_e             dir_i,
  output logic [WIDTH-1:0] nxt_o
);
  localparam logic [WIDTH-1:0] TERM = WIDTH'(term_count(DECADE, WIDTH));
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  generate
    if (DECADE) begin : g_decade
      // out-of-range values fold to the wrap target in one step
      always_comb begin
        if (dir_i == DIR_UP) nxt_o = (cur_i >= TERM) ? '0 : cur_i + ONE;
        else                 nxt_o = (cur_i == '0 || cur_i > TERM) ? TERM : cur_i - ONE;
      end
    end else begin : g_binary
      always_comb begin
        if (dir_i == DIR_UP) nxt_o = cur_i + ONE;
        else                 nxt_o = cur_i - ONE;
      end
    end
  endgenerate
endmodule

// File: rtl/updown_terminal.sv
module updown_terminal
  import updown_counter_pkg::*;
#(
  parameter int unsigned WIDTH  = 4,
  parameter bit          DECADE = 1'b0
) (
  input  logic             clk_i,
  input  logic             enable_ni,
  input  logic [WIDTH-1:0] cur_i,
  input  dir_e             dir_i,
  output logic             max_min_o,
  output logic             ripple_no
);
  localparam logic [WIDTH-1:0] TERM = WIDTH'(term_count(DECADE, WIDTH));

  always_comb begin
    max_min_o = (dir_i == DIR_UP) ? (cur_i == TERM) : (cur_i == '0);
    ripple_no = ~(~clk_i & ~enable_ni & max_min_o);
  end
endmodule

// File: rtl/updown_cascade_counter.sv
module updown_cascade_counter
  import updown_counter_pkg::*;
#(
  parameter int unsigned WIDTH  = 4,
  parameter bit          DECADE = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             enable_ni,
  input  logic             down_i,
  output logic [WIDTH-1:0] count_o,
  output logic             max_min_o,
  output logic             ripple_no
);
  logic [WIDTH-1:0] cnt_q, cnt_nxt;
  dir_e             dir;

  assign dir = dir_e'(down_i);

  updown_next #(.WIDTH(WIDTH), .DECADE(DECADE)) u_next (
    .cur_i (cnt_q),
    .dir_i (dir),
    .nxt_o (cnt_nxt)
  );

  // load is level-effective: captured on its falling edge and on every clock while low
  always_ff @(posedge clk_i or negedge rst_ni or negedge load_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!load_ni)   cnt_q <= data_i;
    else if (!enable_ni) cnt_q <= cnt_nxt;
  end

  updown_terminal #(.WIDTH(WIDTH), .DECADE(DECADE)) u_term (
    .clk_i     (clk_i),
    .enable_ni (enable_ni),
    .cur_i     (cnt_q),
    .dir_i     (dir),
    .max_min_o (max_min_o),
    .ripple_no (ripple_no)
  );

  assign count_o = cnt_q;
endmodule

// File: rtl/updown_cascade_counter_chk.sv
module updown_cascade_counter_chk
  import updown_counter_pkg::*;
#(
  parameter int unsigned WIDTH  = 4,
  parameter bit          DECADE = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_ni,
  input logic             enable_ni,
  input logic             down_i,
  input logic [WIDTH-1:0] count_o,
  input logic             max_min_o,
  input logic             ripple_no
);
  localparam logic [WIDTH-1:0] TERM = WIDTH'(term_count(DECADE, WIDTH));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && $past(load_ni) && $past(enable_ni)) |-> count_o == $past(count_o));

  assert_up_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && $past(load_ni) && !$past(enable_ni) && !$past(down_i) && $past(count_o) < TERM)
      |-> count_o == $past(count_o) + WIDTH'(1));

  assert_up_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && $past(load_ni) && !$past(enable_ni) && !$past(down_i) && $past(count_o) == TERM)
      |-> count_o == '0);

  assert_down_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && $past(load_ni) && !$past(enable_ni) && $past(down_i)
     && $past(count_o) != '0 && $past(count_o) <= TERM)
      |-> count_o == $past(count_o) - WIDTH'(1));

  assert_down_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && $past(load_ni) && !$past(enable_ni) && $past(down_i) && $past(count_o) == '0)
      |-> count_o == TERM);

  assert_ripple_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ripple_no |-> (!enable_ni && max_min_o));

  generate
    if (DECADE) begin : g_dec_chk
      assert_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_ni && $past(load_ni) && !$past(enable_ni)) |-> count_o <= TERM);
    end
  endgenerate
endmodule

bind updown_cascade_counter updown_cascade_counter_chk #(.WIDTH(WIDTH), .DECADE(DECADE)) u_chk (.*);

// File: tb/updown_cascade_counter_tb.sv
module updown_cascade_counter_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0] c8;
    logic [3:0] cd;
    logic       mm0;
    logic       mmd;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_n = 1'b1;
  logic [7:0] data8 = '0;
  logic [3:0] data_d = '0;
  logic       en_n = 1'b1;
  logic       down = 1'b0;

  logic [3:0] c0, c1, cd;
  logic       mm0, mm1, mmd, rip0, rip1, ripd, en1_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t q[$];

  logic [7:0] m8 = '0;
  logic [3:0] md = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // R10: upper stage enabled by carry/borrow of lower stage
  assign en1_n = en_n | ~mm0;

  updown_cascade_counter #(.WIDTH(4), .DECADE(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(data8[3:0]),
    .enable_ni(en_n), .down_i(down), .count_o(c0), .max_min_o(mm0), .ripple_no(rip0));

  updown_cascade_counter #(.WIDTH(4), .DECADE(1'b0)) u_hi (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(data8[7:4]),
    .enable_ni(en1_n), .down_i(down), .count_o(c1), .max_min_o(mm1), .ripple_no(rip1));

  updown_cascade_counter #(.WIDTH(4), .DECADE(1'b1)) u_dec (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(data_d),
    .enable_ni(en_n), .down_i(down), .count_o(cd), .max_min_o(mmd), .ripple_no(ripd));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] dec_next(input logic [3:0] v, input logic dn);
    if (!dn) return (v >= 4'd9) ? 4'd0 : v + 4'd1;
    return (v == 4'd0 || v > 4'd9) ? 4'd9 : v - 4'd1;
  endfunction

  // driver: apply one cycle of stimulus, check the low phase, queue post-edge expectation
  task automatic step(input logic ld, input logic [7:0] d8, input logic [3:0] dd,
                      input logic en, input logic dn, input string tag);
    logic e_mm0, e_mmd;
    exp_t it;
    @(negedge clk);
    load_n = ld; data8 = d8; data_d = dd; en_n = en; down = dn;
    #1;
    if (!ld) begin m8 = d8; md = dd; end
    e_mm0 = dn ? (m8[3:0] == 4'd0) : (m8[3:0] == 4'd15);
    e_mmd = dn ? (md == 4'd0) : (md == 4'd9);
    chk({tag, " R2 R3 chain count in low phase"}, {c1, c0}, m8);
    chk({tag, " R2 R3 decade count in low phase"}, cd, md);
    chk({tag, " R6 max_min low phase"}, mm0, e_mm0);
    chk({tag, " R6 decade max_min low phase"}, mmd, e_mmd);
    chk({tag, " R7 ripple low phase"}, rip0, !(!en && e_mm0));
    chk({tag, " R7 decade ripple low phase"}, ripd, !(!en && e_mmd));
    if (ld && !en) begin
      m8 = dn ? m8 - 8'd1 : m8 + 8'd1;
      md = dec_next(md, dn);
    end
    it.c8  = m8;
    it.cd  = md;
    it.mm0 = dn ? (m8[3:0] == 4'd0) : (m8[3:0] == 4'd15);
    it.mmd = dn ? (md == 4'd0) : (md == 4'd9);
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compare queued expectations after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        chk({it.tag, " chain count after edge"}, {c1, c0}, it.c8);
        chk({it.tag, " decade count after edge"}, cd, it.cd);
        chk({it.tag, " R6 max_min after edge"}, mm0, it.mm0);
        chk({it.tag, " R6 decade max_min after edge"}, mmd, it.mmd);
        chk({it.tag, " R7 ripple high while clock high"}, rip0, 1);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    chk("R1 chain count in reset", {c1, c0}, 0);
    chk("R1 decade count in reset", cd, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1, 8'h00, 4'd0, 1, 0, "R1");
    step(1, 8'h00, 4'd0, 1, 0, "R1");
    // load with enable active: load wins
    step(0, 8'h0E, 4'd7, 0, 0, "R3");
    step(1, 8'h00, 4'd0, 1, 0, "R2");
    for (int i = 0; i < 20; i++) step(1, 8'h00, 4'd0, 0, 0, "R4 R8 R10 up");
    for (int i = 0; i < 3; i++)  step(1, 8'h00, 4'd0, 1, 0, "R2 hold");
    for (int i = 0; i < 30; i++) step(1, 8'h00, 4'd0, 0, 1, "R5 R8 R10 down");
    step(0, 8'h00, 4'd0, 1, 1, "R3");
    for (int i = 0; i < 3; i++)  step(1, 8'h00, 4'd0, 0, 1, "R5 R8 wrap down");
    step(0, 8'hFF, 4'd9, 1, 0, "R3");
    for (int i = 0; i < 2; i++)  step(1, 8'h00, 4'd0, 0, 0, "R4 R8 wrap up");
    // direction flip at terminal value, counting held
    step(0, 8'h0F, 4'd9, 1, 0, "R3");
    step(1, 8'h00, 4'd0, 1, 1, "R6 flip down");
    step(1, 8'h00, 4'd0, 1, 0, "R6 flip up");
    step(0, 8'h00, 4'd0, 1, 0, "R3");
    step(1, 8'h00, 4'd0, 1, 1, "R6 flip at zero");
    // decade out-of-range recovery
    step(0, 8'h00, 4'd12, 1, 0, "R9");
    step(1, 8'h00, 4'd0, 0, 0, "R9 up from 12");
    step(0, 8'h00, 4'd14, 1, 1, "R9");
    step(1, 8'h00, 4'd0, 0, 1, "R9 down from 14");
    step(0, 8'h00, 4'd15, 1, 0, "R9");
    step(1, 8'h00, 4'd0, 0, 0, "R9 up from 15");
    step(0, 8'h00, 4'd10, 1, 1, "R9");
    step(1, 8'h00, 4'd0, 0, 1, "R9 down from 10");
    step(1, 8'h00, 4'd0, 1, 0, "R2 final hold");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule